// File: doc/BRIEF.md
# Memory ECC Error Statistics Unit

This block sits beside a memory controller's ECC checker and turns its stream of error reports into statistics that software can read. Each report arrives as a one-cycle strobe. The strobe carries the error kind (correctable or uncorrectable), a flag that says whether the location is known, and the row, channel and DIMM index of the failing part.

The unit keeps totals for the whole controller and counts per row and per row/channel pair. It keeps separate counts for reports whose location is unknown. It also keeps a per-DIMM-index count that merges the same DIMM slot across all channels. A seconds-since-clear timer sits next to the counters, so software can turn the counts into error rates.

Software reaches all of this through a small register port. Writing the clear register zeros every counter and restarts the timer. A control register sets the logging enables for each error kind and a halt-on-uncorrectable policy. The unit asks for a log entry with a one-cycle pulse and asks for a halt with a sticky level.

Top module: `ecc_err_stats`

## Requirements
- R1: A counted correctable report adds one to the total CE counter (address 0x03). A counted uncorrectable report adds one to the total UE counter (address 0x04).
- R2: A counted report with ev_loc_ok=1 adds one to the row counter at 0x10 + 2*row + kind, where kind is 0 for CE and 1 for UE. It also adds one to the row/channel counter at 0x20 + 2*(row*N_CH + chan) + kind. The no-location counters do not change.
- R3: A counted report with ev_loc_ok=0 adds one only to the no-location CE counter (0x05) or the no-location UE counter (0x06), plus the total. No row, row/channel or DIMM counter changes.
- R4: A counted report with a known location adds one to the DIMM-index counter at 0x30 + dimm, whatever its channel is. The same DIMM index on different channels shares one counter.
- R5: A write of any data to the clear register (0x01) zeros every counter, the seconds timer and the halt request, all in the following cycle.
- R6: The seconds register (0x02) increments once every CYC_PER_SEC clock cycles, counted from the clear write or from reset. It reads 0 after CYC_PER_SEC-1 cycles and 1 after CYC_PER_SEC cycles.
- R7: With halt-on-UE set (control bit 2), an uncorrectable report raises halt_req in the next cycle. halt_req stays high until a clear write or reset. That report changes no counter.
- R8: log_req pulses for exactly one cycle, in the cycle after a report whose kind has its log enable set (control bit 0 for CE, bit 1 for UE). Counting happens whether or not logging is enabled.
- R9: Every counter saturates at its all-ones value instead of wrapping.
- R10: If a clear write and a report occur in the same cycle, the clear wins. The report is not counted, not logged and does not set the halt request.
- R11: The control register (0x00) reads back the 3 bits last written. Any unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | One-cycle error report strobe |
| ev_is_ue | input | 1 | 1 = uncorrectable, 0 = correctable |
| ev_loc_ok | input | 1 | Location fields are valid |
| ev_row | input | RW | Row index of the report |
| ev_chan | input | CW | Channel index of the report |
| ev_dimm | input | DW | DIMM index within its channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for read and write |
| reg_wdata | input | 3 | Write data (control bits) |
| reg_rdata | output | 32 | Combinational read data at reg_addr |
| log_req | output | 1 | One-cycle log request |
| halt_req | output | 1 | Sticky halt request |

## Verification
The hardest situation to reach is a clear write that lands in the same cycle as an error report. A naive bench serialises register writes and events, so it never collides them. The race task drives both strobes from the same falling edge. It then reads totals, log and halt in the next cycle to confirm that nothing leaked through. Saturation is also awkward at full width, so the bench narrows the counters to 4 bits and pushes twenty reports into a single counter. It shrinks the prescaler so the seconds boundary is checked on both sides of the exact cycle.

// File: rtl/ecc_stats_pkg.sv
package ecc_stats_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int CTRL_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL      = 8'h00;
  localparam logic [ADDR_W-1:0] A_CLEAR     = 8'h01;
  localparam logic [ADDR_W-1:0] A_SECS      = 8'h02;
  localparam logic [ADDR_W-1:0] A_TOT_CE    = 8'h03;
  localparam logic [ADDR_W-1:0] A_TOT_UE    = 8'h04;
  localparam logic [ADDR_W-1:0] A_NOLOC_CE  = 8'h05;
  localparam logic [ADDR_W-1:0] A_NOLOC_UE  = 8'h06;
  localparam logic [ADDR_W-1:0] A_ROW_BASE  = 8'h10;
  localparam logic [ADDR_W-1:0] A_RCH_BASE  = 8'h20;
  localparam logic [ADDR_W-1:0] A_DIMM_BASE = 8'h30;

  // control bit positions
  localparam int CB_LOG_CE = 0;
  localparam int CB_LOG_UE = 1;
  localparam int CB_HALT   = 2;

  typedef enum logic {KIND_CE = 1'b0, KIND_UE = 1'b1} err_kind_e;

  function automatic logic [ADDR_W-1:0] row_addr(int r, int k);
    return A_ROW_BASE + ADDR_W'(2 * r + k);
  endfunction

  function automatic logic [ADDR_W-1:0] rch_addr(int r, int c, int nch, int k);
    return A_RCH_BASE + ADDR_W'(2 * (r * nch + c) + k);
  endfunction

  function automatic logic [ADDR_W-1:0] dimm_addr(int d);
    return A_DIMM_BASE + ADDR_W'(d);
  endfunction
endpackage

// File: rtl/ecc_sat_counter.sv
module ecc_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= '0;
    else if (clr)              q <= '0;
    else if (inc && q != MAX)  q <= q + 1'b1;
  end
endmodule

// File: rtl/ecc_sec_timer.sv
module ecc_sec_timer #(
  parameter int CYC_PER_SEC = 1000,
  parameter int SEC_W       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [SEC_W-1:0] secs
);
  localparam int PW = (CYC_PER_SEC > 1) ? $clog2(CYC_PER_SEC) : 1;
  localparam logic [PW-1:0] LAST = PW'(CYC_PER_SEC - 1);
  localparam logic [SEC_W-1:0] SMAX = {SEC_W{1'b1}};

  logic [PW-1:0] pre;
  logic          tick;

  assign tick = (pre == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= '0;
      secs <= '0;
    end else if (clr) begin
      pre  <= '0;
      secs <= '0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick && secs != SMAX) secs <= secs + 1'b1;
    end
  end
endmodule

// File: rtl/ecc_event_decode.sv
module ecc_event_decode (
  input  logic ev_valid,
  input  logic ev_is_ue,
  input  logic ev_loc_ok,
  input  logic clr_wr,
  input  logic log_ce_en,
  input  logic log_ue_en,
  input  logic halt_en,
  output logic count_ce,
  output logic count_ue,
  output logic count_loc,
  output logic halt_set,
  output logic log_set
);
  logic live;
  assign live      = ev_valid && !clr_wr;
  assign count_ce  = live && !ev_is_ue;
  assign count_ue  = live && ev_is_ue && !halt_en;
  assign count_loc = (count_ce || count_ue) && ev_loc_ok;
  assign halt_set  = live && ev_is_ue && halt_en;
  assign log_set   = live && (ev_is_ue ? log_ue_en : log_ce_en);
endmodule

// File: rtl/ecc_err_stats.sv
module ecc_err_stats
  import ecc_stats_pkg::*;
#(
  parameter int N_ROWS      = 4,
  parameter int N_CH        = 2,
  parameter int N_DIMM      = 4,
  parameter int CNT_W       = 16,
  parameter int SEC_W       = 32,
  parameter int CYC_PER_SEC = 1000,
  localparam int RW = (N_ROWS > 1) ? $clog2(N_ROWS) : 1,
  localparam int CW = (N_CH > 1)   ? $clog2(N_CH)   : 1,
  localparam int DW = (N_DIMM > 1) ? $clog2(N_DIMM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic              ev_is_ue,
  input  logic              ev_loc_ok,
  input  logic [RW-1:0]     ev_row,
  input  logic [CW-1:0]     ev_chan,
  input  logic [DW-1:0]     ev_dimm,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              log_req,
  output logic              halt_req
);
  // named internal events
  logic              clr_wr;
  logic              ctrl_wr;
  logic [CTRL_W-1:0] ctrl;
  logic              ctrl_halt;
  logic              count_ce, count_ue, count_loc, halt_set, log_set;

  logic [CNT_W-1:0]  tot_ce, tot_ue, nce, nue;
  logic [SEC_W-1:0]  sec_cnt;
  logic [CNT_W-1:0]  row_cnt  [N_ROWS][2];
  logic [CNT_W-1:0]  rch_cnt  [N_ROWS][N_CH][2];
  logic [CNT_W-1:0]  dimm_cnt [N_DIMM];

  assign clr_wr    = reg_wr && (reg_addr == A_CLEAR);
  assign ctrl_wr   = reg_wr && (reg_addr == A_CTRL);
  assign ctrl_halt = ctrl[CB_HALT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (ctrl_wr) ctrl <= reg_wdata;
  end

  ecc_event_decode u_dec (
    .ev_valid (ev_valid),
    .ev_is_ue (ev_is_ue),
    .ev_loc_ok(ev_loc_ok),
    .clr_wr   (clr_wr),
    .log_ce_en(ctrl[CB_LOG_CE]),
    .log_ue_en(ctrl[CB_LOG_UE]),
    .halt_en  (ctrl_halt),
    .count_ce (count_ce),
    .count_ue (count_ue),
    .count_loc(count_loc),
    .halt_set (halt_set),
    .log_set  (log_set)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log_req  <= 1'b0;
      halt_req <= 1'b0;
    end else begin
      log_req <= log_set;
      if (clr_wr)        halt_req <= 1'b0;
      else if (halt_set) halt_req <= 1'b1;
    end
  end

  ecc_sat_counter #(.W(CNT_W)) u_tot_ce (.clk(clk), .rst_n(rst_n), .clr(clr_wr),
    .inc(count_ce), .q(tot_ce));
  ecc_sat_counter #(.W(CNT_W)) u_tot_ue (.clk(clk), .rst_n(rst_n), .clr(clr_wr),
    .inc(count_ue), .q(tot_ue));
  ecc_sat_counter #(.W(CNT_W)) u_nce (.clk(clk), .rst_n(rst_n), .clr(clr_wr),
    .inc(count_ce && !ev_loc_ok), .q(nce));
  ecc_sat_counter #(.W(CNT_W)) u_nue (.clk(clk), .rst_n(rst_n), .clr(clr_wr),
    .inc(count_ue && !ev_loc_ok), .q(nue));

  ecc_sec_timer #(.CYC_PER_SEC(CYC_PER_SEC), .SEC_W(SEC_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(clr_wr), .secs(sec_cnt));

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    for (genvar k = 0; k < 2; k++) begin : g_kind
      logic row_hit;
      assign row_hit = count_loc && (ev_row == RW'(r)) &&
                       ((k == 1) ? ev_is_ue : !ev_is_ue);
      ecc_sat_counter #(.W(CNT_W)) u_row (.clk(clk), .rst_n(rst_n), .clr(clr_wr),
        .inc(row_hit), .q(row_cnt[r][k]));
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
        ecc_sat_counter #(.W(CNT_W)) u_rch (.clk(clk), .rst_n(rst_n), .clr(clr_wr),
          .inc(row_hit && (ev_chan == CW'(c))), .q(rch_cnt[r][c][k]));
      end
    end
  end

  for (genvar d = 0; d < N_DIMM; d++) begin : g_dimm
    ecc_sat_counter #(.W(CNT_W)) u_dimm (.clk(clk), .rst_n(rst_n), .clr(clr_wr),
      .inc(count_loc && (ev_dimm == DW'(d))), .q(dimm_cnt[d]));
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:     reg_rdata = DATA_W'(ctrl);
      A_SECS:     reg_rdata = DATA_W'(sec_cnt);
      A_TOT_CE:   reg_rdata = DATA_W'(tot_ce);
      A_TOT_UE:   reg_rdata = DATA_W'(tot_ue);
      A_NOLOC_CE: reg_rdata = DATA_W'(nce);
      A_NOLOC_UE: reg_rdata = DATA_W'(nue);
      default:    reg_rdata = '0;
    endcase
    for (int r = 0; r < N_ROWS; r++) begin
      for (int k = 0; k < 2; k++) begin
        if (reg_addr == row_addr(r, k)) reg_rdata = DATA_W'(row_cnt[r][k]);
        for (int c = 0; c < N_CH; c++)
          if (reg_addr == rch_addr(r, c, N_CH, k)) reg_rdata = DATA_W'(rch_cnt[r][c][k]);
      end
    end
    for (int d = 0; d < N_DIMM; d++)
      if (reg_addr == dimm_addr(d)) reg_rdata = DATA_W'(dimm_cnt[d]);
  end
endmodule

// File: rtl/ecc_err_stats_chk.sv
module ecc_err_stats_chk #(
  parameter int CNT_W = 16,
  parameter int SEC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_valid,
  input logic             ev_is_ue,
  input logic             ev_loc_ok,
  input logic             log_req,
  input logic             halt_req,
  input logic             clr_wr,
  input logic             ctrl_halt,
  input logic             count_ce,
  input logic [CNT_W-1:0] tot_ce,
  input logic [CNT_W-1:0] tot_ue,
  input logic [CNT_W-1:0] nce,
  input logic [SEC_W-1:0] sec_cnt
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  assert_total_ce_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (count_ce && tot_ce != MAX) |=> tot_ce == CNT_W'($past(tot_ce) + 1'b1));

  assert_noloc_ce_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_is_ue && !ev_loc_ok && !clr_wr && nce != MAX)
      |=> nce == CNT_W'($past(nce) + 1'b1));

  assert_clear_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (tot_ce == '0 && tot_ue == '0 && nce == '0 && sec_cnt == '0 && !halt_req));

  assert_sec_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> (sec_cnt == $past(sec_cnt) || sec_cnt == SEC_W'($past(sec_cnt) + 1'b1)));

  assert_halt_no_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_is_ue && ctrl_halt && !clr_wr) |=> (halt_req && $stable(tot_ue)));

  assert_log_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    log_req |-> $past(ev_valid && !clr_wr));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tot_ce == MAX && !clr_wr) |=> tot_ce == MAX);

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && ev_valid) |=> (!log_req && !halt_req && tot_ce == '0 && tot_ue == '0));
endmodule

bind ecc_err_stats ecc_err_stats_chk #(.CNT_W(CNT_W), .SEC_W(SEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_is_ue(ev_is_ue),
  .ev_loc_ok(ev_loc_ok), .log_req(log_req), .halt_req(halt_req), .clr_wr(clr_wr),
  .ctrl_halt(ctrl_halt), .count_ce(count_ce), .tot_ce(tot_ce), .tot_ue(tot_ue),
  .nce(nce), .sec_cnt(sec_cnt));

// File: tb/ecc_err_stats_tb.sv
module ecc_err_stats_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_ROWS = 4, N_CH = 2, N_DIMM = 4, CNT_W = 4, SEC_W = 32, CPS = 10;

  logic        clk = 0, rst_n = 0;
  logic        ev_valid = 0, ev_is_ue = 0, ev_loc_ok = 0;
  logic [1:0]  ev_row = 0;
  logic        ev_chan = 0;
  logic [1:0]  ev_dimm = 0;
  logic        reg_wr = 0;
  logic [7:0]  reg_addr = 0;
  logic [2:0]  reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        log_req, halt_req;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_err_stats #(.N_ROWS(N_ROWS), .N_CH(N_CH), .N_DIMM(N_DIMM), .CNT_W(CNT_W),
    .SEC_W(SEC_W), .CYC_PER_SEC(CPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_is_ue(ev_is_ue),
    .ev_loc_ok(ev_loc_ok), .ev_row(ev_row), .ev_chan(ev_chan), .ev_dimm(ev_dimm),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .log_req(log_req), .halt_req(halt_req));

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // read at a falling edge; the combinational readback settles after 1 time unit
  task automatic rd(input logic [7:0] a, input longint exp, input string req, input string what);
    reg_addr = a; #1;
    check(req, what, reg_rdata, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [2:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic ev(input bit ue, input bit loc, input int row, input int ch, input int dimm);
    @(negedge clk);
    ev_valid = 1; ev_is_ue = ue; ev_loc_ok = loc;
    ev_row = 2'(row); ev_chan = 1'(ch); ev_dimm = 2'(dimm);
    @(negedge clk); ev_valid = 0;
  endtask

  function automatic logic [7:0] a_row(int r, int k); return 8'h10 + 8'(2*r + k); endfunction
  function automatic logic [7:0] a_rch(int r, int c, int k); return 8'h20 + 8'(2*(r*N_CH + c) + k); endfunction

  task automatic t_reset;
    @(negedge clk);
    rd(8'h03, 0, "R1", "total CE after reset");
    rd(8'h04, 0, "R1", "total UE after reset");
    check("R7", "halt after reset", halt_req, 0);
    check("R8", "log after reset", log_req, 0);
  endtask

  task automatic t_located;
    wr(8'h01, 0);
    ev(0, 1, 2, 1, 0);
    ev(1, 1, 3, 0, 1);
    ev(0, 1, 2, 0, 2);
    rd(8'h03, 2, "R1", "total CE");
    rd(8'h04, 1, "R1", "total UE");
    rd(a_row(2, 0), 2, "R2", "row2 CE");
    rd(a_row(3, 1), 1, "R2", "row3 UE");
    rd(a_row(0, 0), 0, "R2", "row0 CE untouched");
    rd(a_rch(2, 1, 0), 1, "R2", "row2 ch1 CE");
    rd(a_rch(2, 0, 0), 1, "R2", "row2 ch0 CE");
    rd(a_rch(3, 0, 1), 1, "R2", "row3 ch0 UE");
    rd(8'h05, 0, "R2", "no-location CE untouched");
  endtask

  task automatic t_noinfo;
    wr(8'h01, 0);
    ev(0, 0, 1, 1, 1);
    ev(1, 0, 1, 1, 1);
    ev(1, 0, 0, 0, 0);
    rd(8'h05, 1, "R3", "no-location CE");
    rd(8'h06, 2, "R3", "no-location UE");
    rd(8'h04, 2, "R3", "total UE");
    rd(a_row(1, 0), 0, "R3", "row1 CE untouched");
    rd(a_rch(1, 1, 1), 0, "R3", "row1 ch1 UE untouched");
    rd(8'h31, 0, "R3", "dimm1 untouched");
  endtask

  task automatic t_dimm;
    wr(8'h01, 0);
    ev(0, 1, 0, 0, 1);
    ev(0, 1, 1, 1, 1);
    ev(1, 1, 2, 1, 1);
    ev(0, 1, 3, 0, 3);
    rd(8'h31, 3, "R4", "dimm1 across channels");
    rd(8'h33, 1, "R4", "dimm3");
    rd(8'h30, 0, "R4", "dimm0 untouched");
  endtask

  task automatic t_log;
    wr(8'h01, 0);
    wr(8'h00, 3'b001);
    ev(0, 1, 0, 0, 0);
    check("R8", "log pulse after CE", log_req, 1);
    @(negedge clk);
    check("R8", "log pulse one cycle", log_req, 0);
    ev(1, 1, 0, 0, 0);
    check("R8", "no log for UE when UE log off", log_req, 0);
    rd(8'h04, 1, "R8", "UE counted with logging off");
    wr(8'h00, 3'b010);
    ev(1, 0, 0, 0, 0);
    check("R8", "log pulse after UE", log_req, 1);
    wr(8'h00, 3'b000);
  endtask

  task automatic t_halt;
    wr(8'h01, 0);
    wr(8'h00, 3'b100);
    ev(1, 1, 1, 0, 0);
    check("R7", "halt raised", halt_req, 1);
    rd(8'h04, 0, "R7", "UE not counted");
    rd(a_row(1, 1), 0, "R7", "row UE not counted");
    rd(8'h30, 0, "R7", "dimm not counted");
    ev(0, 1, 1, 0, 0);
    check("R7", "halt sticky", halt_req, 1);
    rd(8'h03, 1, "R7", "CE still counted");
    wr(8'h01, 0);
    check("R7", "halt cleared by clear write", halt_req, 0);
    wr(8'h00, 3'b011);
  endtask

  task automatic t_race;
    wr(8'h01, 0);
    wr(8'h00, 3'b111);
    @(negedge clk);
    reg_wr = 1; reg_addr = 8'h01; reg_wdata = 3'b101;
    ev_valid = 1; ev_is_ue = 1; ev_loc_ok = 1; ev_row = 0; ev_chan = 0; ev_dimm = 0;
    @(negedge clk);
    reg_wr = 0; ev_valid = 0;
    check("R10", "no log on race", log_req, 0);
    check("R10", "no halt on race", halt_req, 0);
    rd(8'h04, 0, "R10", "total UE on race");
    rd(8'h30, 0, "R10", "dimm0 on race");
    wr(8'h00, 3'b000);
  endtask

  task automatic t_seconds;
    @(negedge clk); reg_wr = 1; reg_addr = 8'h01;
    @(negedge clk); reg_wr = 0;
    // clear took effect at the edge before this falling edge: 0 cycles counted
    repeat (CPS - 1) @(negedge clk);
    rd(8'h02, 0, "R6", "seconds before boundary");
    @(negedge clk);
    rd(8'h02, 1, "R6", "seconds at boundary");
    repeat (CPS) @(negedge clk);
    rd(8'h02, 2, "R6", "seconds second tick");
    wr(8'h01, 0);
    rd(8'h02, 0, "R5", "seconds cleared");
  endtask

  task automatic t_saturate;
    wr(8'h01, 0);
    for (int i = 0; i < 20; i++) ev(0, 1, 1, 1, 2);
    rd(8'h03, 15, "R9", "total CE saturated");
    rd(a_rch(1, 1, 0), 15, "R9", "row1 ch1 CE saturated");
    rd(8'h32, 15, "R9", "dimm2 saturated");
    wr(8'h01, 0);
    rd(8'h03, 0, "R5", "total CE cleared");
    rd(a_row(1, 0), 0, "R5", "row CE cleared");
    rd(8'h32, 0, "R5", "dimm cleared");
  endtask

  task automatic t_regs;
    wr(8'h00, 3'b101);
    @(negedge clk);
    rd(8'h00, 5, "R11", "control readback");
    rd(8'h07, 0, "R11", "unmapped 0x07");
    rd(8'h3F, 0, "R11", "unmapped 0x3F");
    rd(8'hFF, 0, "R11", "unmapped 0xFF");
    wr(8'h00, 3'b000);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_located();
        t_noinfo();
        t_dimm();
        t_log();
        t_halt();
        t_race();
        t_seconds();
        t_saturate();
        t_regs();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule